// File: doc/BRIEF.md
# Device interrupt glitch qualifier

This block cleans up the interrupt request of a storage device before it reaches an interrupt controller. The device asks for service by holding its request line high. The source that watches that line reports an event on every change of level, in either direction. On a poorly routed board the line can also ring, so a bare edge report says little about what the device wants.

Each edge event starts a qualification sequence. The block samples the synchronised line twice, on two consecutive cycles, and calls the attempt good when both samples are equal. It keeps trying until a pair agrees or the retry budget runs out. A pair that agrees high is forwarded as a single-cycle interrupt pulse. An agreed low level is reported as a dropped event, and so is a line that never settles. In both of those cases the event still counts as handled and nothing is forwarded. Edge events that arrive while a sequence is running fold into that sequence.

Top module: `irq_qual`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq_fwd` and `drop_evt` are low and no sequence is running.
- R2: `irq_raw` passes through a two-flop synchroniser. The level sampled in cycle k is the `irq_raw` value captured two clock edges before the start of that cycle. Cycle k=0 is the cycle after the edge that captures `edge_evt`.
- R3: `edge_evt` carries no direction. A pulse while idle always starts a sequence that ends in exactly one outcome pulse, whether the line rose or fell.
- R4: Attempt a (a=0,1,...) samples the line in cycles 2a and 2a+1. If both samples are 1, `irq_fwd` is high for exactly cycle 2a+1.
- R5: If both samples of an attempt are 0, `drop_evt` is high for exactly cycle 2a+1 and `irq_fwd` stays low.
- R6: If the samples of an attempt differ, the block starts the next attempt at once. At most MAX_TRIES (default 8) attempts are made. When all of them mismatch, `drop_evt` pulses in cycle 2*MAX_TRIES-1 (cycle 15 by default).
- R7: An `edge_evt` pulse during a running sequence neither restarts it nor adds an outcome.
- R8: With no `edge_evt`, neither output ever rises, whatever `irq_raw` does.
- R9: `irq_fwd` and `drop_evt` are never high together, and each sequence produces exactly one outcome pulse.
- R10: Every new sequence starts with the full retry budget, whatever the previous sequence used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_raw | input | 1 | Raw interrupt request level from the device, high means service wanted |
| edge_evt | input | 1 | Single-cycle report of any change on the request line |
| irq_fwd | output | 1 | Single-cycle qualified interrupt |
| drop_evt | output | 1 | Single-cycle notice that an event was absorbed as handled |

## Verification
The hardest case to reach is a line that keeps disagreeing until the last allowed attempt. That case decides whether the budget is exactly eight attempts, and it is what separates a forward from a drop at cycle 15. The bench presets `irq_raw` one cycle ahead of the edge, so the synchroniser delay lines up each stimulus bit with a known sample cycle. It then feeds a 16-bit per-cycle level pattern, including alternating patterns that settle high or low only in the final pair. An extra edge is injected part-way through one such pattern to exercise merging.

// File: rtl/irq_qual.sv
module irq_qual #(
  parameter int MAX_TRIES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic edge_evt,
  output logic irq_fwd,
  output logic drop_evt
);

  localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_e;

  st_e                    st_q, st_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [TW-1:0]          tries_q, tries_d;
  logic                   line_q, first_q, busy;
  logic                   in_second, agree, differ, last_try;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
  end

  assign line_q    = sync_q[SYNC_STAGES-1];
  assign busy      = (st_q != ST_IDLE);
  assign in_second = (st_q == ST_SECOND);
  assign agree     = in_second && (line_q == first_q);
  assign differ    = in_second && (line_q != first_q);
  assign last_try  = (tries_q == LAST_TRY);

  assign irq_fwd  = agree && line_q;
  assign drop_evt = (agree && !line_q) || (differ && last_try);

  always_comb begin
    st_d    = st_q;
    tries_d = tries_q;
    case (st_q)
      ST_IDLE: begin
        tries_d = '0;
        if (edge_evt) st_d = ST_FIRST;
      end
      ST_FIRST: st_d = ST_SECOND;
      ST_SECOND: begin
        if (agree || last_try) begin
          st_d    = ST_IDLE;
          tries_d = '0;
        end else begin
          st_d    = ST_FIRST;
          tries_d = tries_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tries_q <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tries_q <= tries_d;
      if (st_q == ST_FIRST) first_q <= line_q;
    end
  end

endmodule

// File: rtl/irq_qual_chk.sv
module irq_qual_chk #(
  parameter int TW        = 3,
  parameter int MAX_TRIES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_evt,
  input logic          irq_fwd,
  input logic          drop_evt,
  input logic          line_q,
  input logic          busy,
  input logic [TW-1:0] tries
);

  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_fwd && drop_evt));

  // R4
  fwd_high_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |-> (line_q && $past(line_q)));

  // R4
  fwd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fwd |=> !irq_fwd);

  // R8
  out_needs_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fwd || drop_evt) |-> busy);

  // R9
  outcome_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fwd || drop_evt) |=> !busy);

  // R3
  edge_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && edge_evt) |=> busy);

  // R6
  try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tries) < MAX_TRIES);

  // R10
  idle_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tries == '0));

endmodule

bind irq_qual irq_qual_chk #(.TW(TW), .MAX_TRIES(MAX_TRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_evt (edge_evt),
  .irq_fwd  (irq_fwd),
  .drop_evt (drop_evt),
  .line_q   (line_q),
  .busy     (busy),
  .tries    (tries_q)
);

// File: tb/sim_irq_qual.sv
`timescale 1ns/1ps
module sim_irq_qual;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_raw = 1'b0;
  logic edge_evt = 1'b0;
  logic irq_fwd, drop_evt;
  int   total = 0;
  int   fails = 0;

  always #2.5 clk = ~clk;

  irq_qual u0 (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .edge_evt(edge_evt),
    .irq_fwd(irq_fwd), .drop_evt(drop_evt)
  );

  // {pattern[15:0] level per cycle k, kind 1=fwd 2=drop, outcome cycle, merge}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {16'hFFFF, 2'd1, 4'd1,  1'b0},
    {16'h0000, 2'd2, 4'd1,  1'b0},
    {16'hFFFD, 2'd1, 4'd3,  1'b0},
    {16'h5555, 2'd2, 4'd15, 1'b0},
    {16'hAAAA, 2'd2, 4'd15, 1'b0},
    {16'hD555, 2'd1, 4'd15, 1'b0},
    {16'h1555, 2'd2, 4'd15, 1'b0},
    {16'h0002, 2'd2, 4'd3,  1'b0},
    {16'hFFFE, 2'd1, 4'd3,  1'b0},
    {16'h5555, 2'd2, 4'd15, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [15:0] pat, input int ek, input int ec,
                         input bit merge, input string tag);
    int gk = 0;
    int gc = -1;
    int extra = 0;
    @(negedge clk) irq_raw = pat[0];
    @(negedge clk) begin irq_raw = pat[1]; edge_evt = 1'b1; end
    @(negedge clk) begin irq_raw = pat[2]; edge_evt = 1'b0; end
    for (int j = 0; j < 22; j++) begin
      if (irq_fwd || drop_evt) begin
        if (gk == 0) begin
          gk = (irq_fwd && drop_evt) ? 3 : (irq_fwd ? 1 : 2);
          gc = j;
        end else extra++;
      end
      edge_evt = (merge && j == 4);
      @(negedge clk);
      irq_raw = (j + 3 < 16) ? pat[j + 3] : pat[15];
    end
    edge_evt = 1'b0;
    check(gk == ek, {tag, " outcome kind"}, gk, ek);
    check(gc == ec, {tag, " outcome cycle"}, gc, ec);
    check(gk != 0, "R3 edge produced an outcome", gk, ek);
    check(extra == 0, "R9 single outcome per event", extra, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs low during reset
    check(!irq_fwd && !drop_evt, "R1 reset outputs", {irq_fwd, drop_evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!irq_fwd && !drop_evt, "R1 after reset", {irq_fwd, drop_evt}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VEC[i][0])                  tag = "R7 merged edge";
      else if (i == 4)                tag = "R10 fresh budget";
      else if (i == 8)                tag = "R2 sync latency";
      else if (VEC[i][4:1] > 4'd1)    tag = "R6 retry";
      else if (VEC[i][6:5] == 2'd1)   tag = "R4 high pair";
      else                            tag = "R5 low pair";
      run_seq(VEC[i][22:7], int'(VEC[i][6:5]), int'(VEC[i][4:1]), VEC[i][0], tag);
    end

    // R8 line activity without any edge report
    begin
      int seen = 0;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        irq_raw = (j % 3 != 0);
        if (irq_fwd || drop_evt) seen++;
      end
      check(seen == 0, "R8 no edge no outcome", seen, 0);
    end

    // R10 two unsettled events back to back, each uses the full budget
    run_seq(16'hAAAA, 2, 15, 1'b0, "R10 back-to-back first");
    run_seq(16'hAAAA, 2, 15, 1'b0, "R10 back-to-back second");

    // R1 reset mid-sequence clears activity
    @(negedge clk) edge_evt = 1'b1;
    @(negedge clk) begin edge_evt = 1'b0; irq_raw = 1'b1; rst_n = 1'b0; end
    @(negedge clk) rst_n = 1'b1;
    begin
      int seen = 0;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (irq_fwd || drop_evt) seen++;
      end
      check(seen == 0, "R1 reset aborts sequence", seen, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule